// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is an I2C target that sits in front of a 256-byte memory. It oversamples the two bus lines with the system clock and recognises START, repeated START and STOP conditions. It compares the 7-bit device address it receives against its own, and it acknowledges and moves bytes in both directions. Reads are served through an internal address pointer. The pointer persists between transactions and always names the location just after the last byte touched.

A master has three ways to read. It can open a read directly at wherever the pointer stands. It can first send a write header that carries only a byte address, then a repeated START and a read header, and so fetch from any chosen location. It can also keep acknowledging bytes to stream through the memory, wrapping from the top location to location 0. A write header followed by data bytes stores them at the pointer with post-increment. A separate preload port lets the surrounding logic, or a testbench, fill the array directly.

The bus is modelled open-drain. The block reads the resolved SCL and SDA levels and pulls SDA low through an output enable. It never drives either line high.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, sda_oe is 0 and the address pointer is 0. The 256x8 array is written through pre_we/pre_addr/pre_data in one clock cycle.
- R2: A device byte on the bus is sent MSB first: bits [7:1] hold the address (default 7'h50) and bit 0 is the direction, where 1 means read. After a START, a device byte with bits [7:1] = 7'h50 and bit 0 = 1 is acknowledged with SDA low in the 9th clock. The byte at the pointer is then shifted out MSB first.
- R3: Each data byte that the master acknowledges is followed by the byte at the next address.
- R4: During a streamed read the pointer steps from 255 to 0 and transmission continues.
- R5: Between transactions the pointer keeps its value, one past the last byte read or written. A new read that starts at the pointer resumes there.
- R6: A write header (bit 0 = 0) followed by one byte address loads the pointer and is acknowledged after each byte. A repeated START then writes nothing, and a following read header returns data from the loaded address.
- R7: A device byte whose bits [7:1] differ from the device address gets no acknowledge. SDA stays released for the rest of that transaction and the pointer is unchanged.
- R8: When the master answers a data byte with NoACK, SDA is released and stays released until the next START.
- R9: Data bytes that follow a write header and a byte address are each acknowledged and stored at the pointer, which then advances by one.
- R10: SDA is only taken low while SCL is low. A STOP or START in the middle of a byte aborts it without writing, and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Resolved level of the SCL line |
| sda_i | input | 1 | Resolved level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pre_we | input | 1 | Preload write strobe into the array |
| pre_addr | input | AW (8) | Preload address |
| pre_data | input | 8 | Preload data |

## Verification
The assertions watch, on every cycle, properties that any bus traffic must respect:
- SDA is only pulled low while SCL is low.
- SDA is released in the idle state and after a STOP.
- The pointer only moves on an SCL falling edge, and only by one step (including the 255 to 0 wrap) or by an explicit address load.

Which byte comes back, whether an acknowledge appears, and whether a dummy write or an aborted byte leaves memory untouched can only be shown by the bench's transaction scenarios. These include:
- random reads that cross the top of memory;
- resumed reads after NoACK;
- a foreign device address;
- stored writes;
- a data byte cut short by a STOP.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter logic [6:0] DEV_ID = 7'h50,
  parameter int         AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_RDATA} st_t;

  logic [2:0]    scl_q, sda_q;
  logic          scl_s, scl_p, sda_s, sda_p;
  logic          scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [7:0]    sr, tx, rd_byte;
  logic [3:0]    cnt;
  logic          nack, rw, oe, dev_hit, wr_en, addr_ld;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  assign scl_s     = scl_q[1];
  assign scl_p     = scl_q[2];
  assign sda_s     = sda_q[1];
  assign sda_p     = sda_q[2];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  assign dev_hit = (sr[7:1] == DEV_ID);
  assign rd_byte = mem[ptr];
  assign wr_en   = scl_fall && (st == S_WDATA) && (cnt == 4'd8);
  assign addr_ld = scl_fall && (st == S_ADDR) && (cnt == 4'd8);
  assign sda_oe  = oe;

  always_ff @(posedge clk)
    if (pre_we)     mem[pre_addr] <= pre_data;
    else if (wr_en) mem[ptr]      <= sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      sr   <= '0;
      tx   <= '0;
      ptr  <= '0;
      oe   <= 1'b0;
      nack <= 1'b0;
      rw   <= 1'b0;
    end else if (bus_start) begin
      st  <= S_DEV;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (bus_stop) begin
      st  <= S_IDLE;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd9)  cnt <= cnt + 4'd1;
        if (cnt < 4'd8)  sr  <= {sr[6:0], sda_s};
        if (cnt == 4'd8) nack <= sda_s;
      end else if (scl_fall) begin
        if (st == S_RDATA) begin
          if (cnt == 4'd9) begin
            if (nack) begin
              st <= S_IDLE;
              oe <= 1'b0;
            end else begin
              tx  <= rd_byte;
              ptr <= ptr + 1'b1;
              oe  <= ~rd_byte[7];
              cnt <= '0;
            end
          end else if (cnt == 4'd8) begin
            oe <= 1'b0;
          end else if (cnt != 4'd0) begin
            tx <= {tx[6:0], 1'b0};
            oe <= ~tx[6];
          end
        end else if (cnt == 4'd8) begin
          case (st)
            S_DEV:
              if (dev_hit) begin
                oe <= 1'b1;
                rw <= sr[0];
              end else begin
                st <= S_IDLE;
              end
            S_ADDR: begin
              ptr <= AW'(sr);
              oe  <= 1'b1;
            end
            S_WDATA: begin
              ptr <= ptr + 1'b1;
              oe  <= 1'b1;
            end
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          oe  <= 1'b0;
          cnt <= '0;
          if (st == S_DEV && rw) begin
            st  <= S_RDATA;
            tx  <= rd_byte;
            ptr <= ptr + 1'b1;
            oe  <= ~rd_byte[7];
          end else if (st == S_DEV) begin
            st <= S_ADDR;
          end else begin
            st <= S_WDATA;
          end
        end
      end
    end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          scl_fall,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          sda_oe,
  input logic [2:0]    st,
  input logic [AW-1:0] ptr,
  input logic          addr_ld
);
  a_r10_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  a_r10_release_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!$past(scl_s) || $past(bus_start) || $past(bus_stop)));

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == AW'($past(ptr) + 1'b1)) || $past(addr_ld)));

  a_r5_ptr_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(scl_fall));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .bus_start(bus_start), .bus_stop(bus_stop), .sda_oe(sda_oe),
  .st(st), .ptr(ptr), .addr_ld(addr_ld)
);

// File: tb/i2c_eeprom_slave_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_bench;
  localparam int Q = 10;
  localparam logic [15:0] VEC [6] = '{16'h1003, 16'hFD05, 16'h0001,
                                      16'h8002, 16'hFF02, 16'h3C04};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic pre_we = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;
  logic sda_oe, sda_line;
  logic [7:0] model [256];
  logic [7:0] bptr = 8'h00;
  int n_chk = 0, n_err = 0, viol = 0;
  bit done = 0;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  always @(negedge clk) begin
    if (m_scl && (sda_oe !== prev_oe)) viol++;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n * Q) @(posedge clk);
  endtask

  task automatic bus_start();
    qw(1); m_low = 1'b0;
    qw(1); m_scl = 1'b1;
    qw(1); m_low = 1'b1;
    qw(1); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    qw(1); m_low = 1'b1;
    qw(1); m_scl = 1'b1;
    qw(1); m_low = 1'b0;
    qw(1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      qw(1); m_low = ~b[i];
      qw(1); m_scl = 1'b1;
      qw(2); m_scl = 1'b0;
    end
  endtask

  task automatic wb(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    qw(1); m_low = 1'b0;
    qw(1); m_scl = 1'b1;
    qw(1); ack = ~sda_line;
    qw(1); m_scl = 1'b0;
  endtask

  task automatic rb(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(2); m_scl = 1'b1;
      qw(1); b[i] = sda_line;
      qw(1); m_scl = 1'b0;
    end
    qw(1); m_low = give_ack;
    qw(1); m_scl = 1'b1;
    qw(2); m_scl = 1'b0;
    qw(1); m_low = 1'b0;
  endtask

  task automatic do_read(input bit set_addr, input logic [7:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    logic [7:0] exp;
    bus_start();
    if (set_addr) begin
      wb(8'hA0, ack); check(ack, "R6 write header ack", 8'(ack), 8'd1);
      wb(a, ack);     check(ack, "R6 byte address ack", 8'(ack), 8'd1);
      bus_start();
      exp = a;
    end else begin
      exp = bptr;
    end
    wb(8'hA1, ack); check(ack, "R2 read header ack", 8'(ack), 8'd1);
    for (int i = 0; i < n; i++) begin
      rb(i != n - 1, b);
      if (i > 0 && exp == 8'h00) check(b == model[exp], "R4 wrap data", b, model[exp]);
      else if (i > 0)            check(b == model[exp], "R3 streamed data", b, model[exp]);
      else                       check(b == model[exp], tag, b, model[exp]);
      exp = exp + 8'd1;
    end
    bptr = exp;
    qw(1);
    check(sda_oe == 1'b0, "R8 released after NoACK", 8'(sda_oe), 8'd0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(sda_oe == 1'b0, "R1 reset release", 8'(sda_oe), 8'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 8'(a); pre_data = pat(a); model[a] = pat(a);
    end
    @(negedge clk); pre_we = 1'b0;
    qw(2);
    check(sda_oe == 1'b0, "R1 idle after preload", 8'(sda_oe), 8'd0);

    do_read(1'b0, 8'h00, 1, "R2 current read after reset");
    do_read(1'b0, 8'h00, 1, "R5 resumed current read");

    for (int v = 0; v < 6; v++)
      do_read(1'b1, VEC[v][15:8], int'(VEC[v][7:0]), "R6 random read first byte");

    do_read(1'b0, 8'h00, 2, "R5 resume after streamed read");

    bus_start();
    wb(8'hA3, ack); check(!ack, "R7 foreign address no ack", 8'(ack), 8'd0);
    wb(8'hA1, ack); check(!ack, "R7 bus ignored after mismatch", 8'(ack), 8'd0);
    bus_stop();
    do_read(1'b0, 8'h00, 1, "R7 pointer kept after mismatch");

    bus_start();
    wb(8'hA0, ack); check(ack, "R9 header ack", 8'(ack), 8'd1);
    wb(8'h20, ack); check(ack, "R9 address ack", 8'(ack), 8'd1);
    wb(8'h5A, ack); check(ack, "R9 data0 ack", 8'(ack), 8'd1);
    wb(8'hC3, ack); check(ack, "R9 data1 ack", 8'(ack), 8'd1);
    bus_stop();
    model[8'h20] = 8'h5A; model[8'h21] = 8'hC3; bptr = 8'h22;
    do_read(1'b0, 8'h00, 1, "R9 pointer post-increment after write");
    do_read(1'b1, 8'h20, 2, "R9 stored byte");

    do_read(1'b1, 8'h30, 1, "R6 dummy write left data intact");

    bus_start();
    wb(8'hA0, ack); check(ack, "R10 header ack", 8'(ack), 8'd1);
    wb(8'h70, ack); check(ack, "R10 address ack", 8'(ack), 8'd1);
    send_bits(8'h0F, 4);
    bus_stop();
    bptr = 8'h70;
    do_read(1'b0, 8'h00, 1, "R10 aborted byte wrote nothing");

    check(viol == 0, "R10 SDA moved while SCL high", 8'(viol), 8'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule